// File: doc/BRIEF.md
# Quadword Strided Address Generator

This block produces the memory address stream for one DMA channel. Software supplies a start byte address, a total count of 16-byte quadwords, a transfer mode and a packed stride word. A start strobe launches the channel. The block then presents one quadword-aligned address per beat on a valid/ready stream. The address advances only when the consumer accepts it.

In strided mode the addresses come in runs. The block emits a run of transfer quadwords, then jumps over a run of skipped quadwords, and repeats. Every other mode code walks memory linearly. The total count falls only on accepted quadwords. The transfer ends as soon as the count reaches zero, even partway through a run. At that point the busy flag drops and a one-cycle done pulse is raised.

Top module: `qw_stride_agen`

## Requirements
- R1: Every address presented has bits 3:0 equal to zero. The first address of a transfer is the start address with its low four bits cleared.
- R2: With mode code 0, 1 or 3, each accepted address is followed by the previous address plus 16.
- R3: With mode code 2, the run length is taken from bits 23:16 of the stride word and the skip length from bits 7:0. After the last accepted address of a run, the next address is that address plus 16 × (skip + 1). Within a run, the next address is the previous one plus 16.
- R4: In mode 2, a run length of 0 means runs of 256 quadwords. A skip length of 0 makes consecutive runs contiguous.
- R5: A transfer emits exactly the total count of addresses, one per valid-and-ready beat, and may end partway through a run.
- R6: While valid is high and ready is low, the address and valid hold steady.
- R7: Busy and valid are high from the cycle after an accepted start until the cycle after the final beat. Done is high for exactly that one following cycle.
- R8: A start with a total count of 0 raises done in the next cycle, and no valid address is presented.
- R9: A start strobe that arrives while busy is ignored. The running transfer continues with its original settings.
- R10: After reset, busy, valid and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch strobe, taken only while idle |
| mode_i | input | 2 | Transfer mode; 2 selects strided, others linear |
| base_addr_i | input | ADDR_W | Start byte address |
| total_qw_i | input | CNT_W | Total quadwords to emit |
| stride_cfg_i | input | 32 | Packed stride word: run at 23:16, skip at 7:0 |
| ready_i | input | 1 | Consumer accepts the current address |
| valid_o | output | 1 | Address is valid |
| addr_o | output | ADDR_W | Current quadword byte address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Linear transfers in each non-strided mode code show that only code 2 changes the stepping. Strided transfers use short runs, zero skips, a zero run length crossing 256 beats, and totals that stop partway through a run. Together these separate the run counter reload, the skip arithmetic and the count termination. Random ready stalls show whether the address and count move only on accepted beats. A start strobe during a transfer and a zero-count start probe the idle-only launch path. An unaligned start address checks the quadword alignment.

// File: rtl/qw_stride_pkg.sv
package qw_stride_pkg;

    localparam int QW_BYTES  = 16;
    localparam int QW_SHIFT  = 4;
    localparam int RUN_W     = 8;
    localparam int SKIP_W    = 8;
    localparam int CFG_W     = 32;
    localparam int RUN_LSB   = 16;
    localparam int SKIP_LSB  = 0;

    typedef enum logic [1:0] {
        XFER_LINEAR  = 2'd0,
        XFER_CHAINED = 2'd1,
        XFER_STRIDED = 2'd2,
        XFER_RSVD    = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic [RUN_W-1:0]  run_len;
        logic [SKIP_W-1:0] skip_len;
    } stride_cfg_t;

    function automatic stride_cfg_t unpack_stride(input logic [CFG_W-1:0] w);
        stride_cfg_t c;
        c.run_len  = w[RUN_LSB +: RUN_W];
        c.skip_len = w[SKIP_LSB +: SKIP_W];
        return c;
    endfunction

    function automatic logic is_strided(input logic [1:0] m);
        return xfer_mode_e'(m) == XFER_STRIDED;
    endfunction

endpackage

// File: rtl/qw_agen_ctrl.sv
module qw_agen_ctrl
    import qw_stride_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             beat_i,
    output logic             launch_o,
    output logic             busy_o,
    output logic             done_o
);

    logic [CNT_W-1:0] remain_q;
    logic             busy_q;
    logic             done_q;
    logic             accept;
    logic             last_beat;

    assign accept    = start_i && !busy_q;
    assign launch_o  = accept && (total_i != '0);
    assign last_beat = busy_q && beat_i && (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            remain_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (total_i == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q   <= 1'b1;
                    remain_q <= total_i;
                end
            end else if (busy_q && beat_i) begin
                remain_q <= remain_q - CNT_W'(1);
                if (last_beat) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    AST_BUSY_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (remain_q != '0)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R7
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_i && !beat_i) |=> (busy_q && remain_q == $past(remain_q))); // R9
    AST_ZERO_TOTAL: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q && total_i == '0) |=> (done_q && !busy_q)); // R8

endmodule

// File: rtl/qw_run_tracker.sv
module qw_run_tracker
    import qw_stride_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [RUN_W-1:0] run_len_i,
    input  logic             beat_i,
    output logic             run_end_o
);

    logic [RUN_W-1:0] left_q;
    logic [RUN_W-1:0] reload_q;

    // A loaded zero wraps through all counter values: a run of 2**RUN_W beats.
    assign run_end_o = (left_q == RUN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q   <= '0;
            reload_q <= '0;
        end else if (load_i) begin
            left_q   <= run_len_i;
            reload_q <= run_len_i;
        end else if (beat_i) begin
            if (run_end_o) begin
                left_q <= reload_q;
            end else begin
                left_q <= left_q - RUN_W'(1);
            end
        end
    end

    AST_RUN_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (beat_i && !load_i && !run_end_o) |=> (left_q == $past(left_q) - RUN_W'(1))); // R4
    AST_RUN_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (beat_i && !load_i && run_end_o) |=> $stable(reload_q)); // R3

endmodule

// File: rtl/qw_addr_step.sv
module qw_addr_step
    import qw_stride_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              strided_i,
    input  logic [SKIP_W-1:0] skip_i,
    input  logic              beat_i,
    input  logic              run_end_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] LINEAR_STEP = ADDR_W'(QW_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic              strided_q;
    logic [SKIP_W-1:0] skip_q;
    logic [SKIP_W:0]   skip_plus;
    logic [ADDR_W-1:0] jump_bytes;
    logic [ADDR_W-1:0] step;

    always_comb begin
        skip_plus  = {1'b0, skip_q} + {{SKIP_W{1'b0}}, 1'b1};
        jump_bytes = ADDR_W'(skip_plus) << QW_SHIFT;
        step       = (strided_q && run_end_i) ? jump_bytes : LINEAR_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            strided_q <= 1'b0;
            skip_q    <= '0;
        end else if (load_i) begin
            addr_q    <= {base_i[ADDR_W-1:QW_SHIFT], {QW_SHIFT{1'b0}}};
            strided_q <= strided_i;
            skip_q    <= skip_i;
        end else if (beat_i) begin
            addr_q <= addr_q + step;
        end
    end

    assign addr_o = addr_q;

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        addr_q[QW_SHIFT-1:0] == '0); // R1
    AST_LINEAR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (beat_i && !load_i && !strided_q) |=> (addr_q - $past(addr_q) == LINEAR_STEP)); // R2
    AST_IN_RUN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (beat_i && !load_i && strided_q && !run_end_i) |=> (addr_q - $past(addr_q) == LINEAR_STEP)); // R3

endmodule

// File: rtl/qw_stride_agen.sv
module qw_stride_agen
    import qw_stride_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  total_qw_i,
    input  logic [CFG_W-1:0]  stride_cfg_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              done_o
);

    stride_cfg_t cfg;
    logic        launch;
    logic        busy;
    logic        beat;
    logic        run_end;
    logic        unused_cfg_bits;

    assign cfg             = unpack_stride(stride_cfg_i);
    assign unused_cfg_bits = ^{stride_cfg_i[CFG_W-1:RUN_LSB+RUN_W],
                               stride_cfg_i[RUN_LSB-1:SKIP_LSB+SKIP_W]};
    assign beat            = busy && ready_i;

    qw_agen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .total_i  (total_qw_i),
        .beat_i   (beat),
        .launch_o (launch),
        .busy_o   (busy),
        .done_o   (done_o)
    );

    qw_run_tracker u_run (
        .clk       (clk),
        .rst       (rst),
        .load_i    (launch),
        .run_len_i (cfg.run_len),
        .beat_i    (beat),
        .run_end_o (run_end)
    );

    qw_addr_step #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load_i    (launch),
        .base_i    (base_addr_i),
        .strided_i (is_strided(mode_i)),
        .skip_i    (cfg.skip_len),
        .beat_i    (beat),
        .run_end_i (run_end),
        .addr_o    (addr_o)
    );

    assign valid_o = busy;
    assign busy_o  = busy;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o))); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !valid_o); // R7

endmodule

// File: tb/qw_stride_agen_tb.sv
module qw_stride_agen_tb;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [1:0]        mode_i = '0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [CNT_W-1:0]  total_qw_i = '0;
    logic [31:0]       stride_cfg_i = '0;
    logic              ready_i = 1'b0;
    logic              valid_o;
    logic [ADDR_W-1:0] addr_o;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    qw_stride_agen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .base_addr_i  (base_addr_i),
        .total_qw_i   (total_qw_i),
        .stride_cfg_i (stride_cfg_i),
        .ready_i      (ready_i),
        .valid_o      (valid_o),
        .addr_o       (addr_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] base,
            input logic [1:0] mode, input int run, input int skip, input int k);
        logic [ADDR_W-1:0] b;
        int r;
        b = {base[ADDR_W-1:4], 4'b0};
        if (mode != 2'd2) return b + ADDR_W'(16 * k);
        r = (run == 0) ? 256 : run;
        return b + ADDR_W'(16 * (k + (k / r) * skip));
    endfunction

    task automatic run_xfer(input logic [ADDR_W-1:0] base, input logic [1:0] mode,
                            input int total, input int run, input int skip,
                            input int poke, input string tag);
        int k;
        @(negedge clk);
        base_addr_i  = base;
        mode_i       = mode;
        total_qw_i   = CNT_W'(total);
        stride_cfg_i = {8'h00, 8'(run), 8'h00, 8'(skip)};
        start_i      = 1'b1;
        ready_i      = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        if (total == 0) begin
            chk(done_o == 1'b1, "R8", "done after zero start", done_o, 1);
            chk(valid_o == 1'b0, "R8", "valid after zero start", valid_o, 0);
            @(negedge clk);
            chk(done_o == 1'b0 && valid_o == 1'b0, "R8", "quiet after zero done",
                {done_o, valid_o}, 0);
            return;
        end
        k = 0;
        while (k < total) begin
            chk(valid_o && busy_o, "R7", "valid/busy during transfer", {valid_o, busy_o}, 3);
            chk(addr_o == exp_addr(base, mode, run, skip, k), tag, "address",
                addr_o, exp_addr(base, mode, run, skip, k));
            // R9: a launch attempt with other settings while busy
            if (k == poke) begin
                start_i     = 1'b1;
                base_addr_i = 32'hDEAD_0000;
                total_qw_i  = '0;
                mode_i      = 2'd2;
            end else begin
                start_i = 1'b0;
            end
            ready_i = ($urandom % 4) != 0;
            if (ready_i) k++;
            @(negedge clk);
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        chk(!valid_o && !busy_o, "R5", "stream stops after total", {valid_o, busy_o}, 0);
        chk(done_o == 1'b1, "R7", "done after last beat", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R7", "done is one cycle", done_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed_ret;
        seed_ret = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        chk(!busy_o && !valid_o && !done_o, "R10", "reset outputs",
            {busy_o, valid_o, done_o}, 0);

        run_xfer(32'h0000_1000, 2'd0, 5, 3, 4, -1, "R2");
        run_xfer(32'h0000_2000, 2'd1, 6, 2, 9, -1, "R2");
        run_xfer(32'h0000_3000, 2'd3, 4, 1, 7, -1, "R2");
        run_xfer(32'h0000_400B, 2'd0, 3, 0, 0, -1, "R1");
        run_xfer(32'h0001_0007, 2'd2, 8, 2, 1, -1, "R1");
        run_xfer(32'h0000_5000, 2'd2, 7, 2, 3, -1, "R3");
        run_xfer(32'h0000_6000, 2'd2, 11, 4, 255, -1, "R3");
        run_xfer(32'h0000_7000, 2'd2, 9, 3, 0, -1, "R4");
        run_xfer(32'h0002_0000, 2'd2, 300, 0, 1, -1, "R4");
        run_xfer(32'h0000_8000, 2'd2, 5, 4, 2, -1, "R5");
        run_xfer(32'h0000_9000, 2'd0, 0, 2, 2, -1, "R8");
        run_xfer(32'h0000_A000, 2'd2, 10, 3, 2, 4, "R9");
        run_xfer(32'h0000_B000, 2'd0, 8, 0, 0, 2, "R9");

        for (int i = 0; i < 12; i++) begin
            logic [1:0] m;
            int tot, rl, sk;
            m   = 2'($urandom % 4);
            tot = 1 + ($urandom % 120);
            rl  = $urandom % 7;
            sk  = $urandom % 256;
            run_xfer({$urandom} & 32'h0FFF_FFFF, m, tot, rl, sk, -1,
                     (m == 2'd2) ? "R3" : "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule